// File: doc/BRIEF.md
# Prescaled Up-Counting Watchdog

This block is a watchdog timer for a peripheral clock domain. A 16-bit counter counts up, advancing once per prescaler tick. When it passes its top value it issues a one-cycle reset request. Software keeps the system alive by pulsing a service strobe before that happens. The service strobe places an 8-bit reload value into the counter's upper byte, zeroes the lower byte and restarts the prescaler. A larger reload value therefore gives a shorter timeout.

The prescaler divides the peripheral clock by one of four ratios, chosen by a 2-bit select with a non-monotonic code. The select is sampled only when a new counting period starts, so a period that is already under way keeps the ratio it started with. A sticky flag records that the watchdog fired. It stays set until software clears it. While the enable input is low the block never fires, and it holds itself ready to start a fresh period.

Top module: `guard_timer`

## Requirements
- R1: The select `div_sel` sets the prescaler ratio: code 0 divides by 2, code 1 by 128, code 2 by 4 and code 3 by 256.
- R2: A service pulse (`kick` high at a clock edge while `en` is high) loads the counter with `{reload_hi, 8'h00}`, restarts the prescaler and samples `div_sel`. With ratio D and no further service, `bite` first goes high directly after the clock edge that comes D*(65536 - 256*reload_hi) edges after the service edge.
- R3: The counter only counts up, by one per prescaler tick. Overflow is the step past 16'hFFFF.
- R4: `bite` is high for exactly one cycle per overflow.
- R5: While `en` is low, `bite` stays low and the counter is held at `{reload_hi, 8'h00}` with the prescaler cleared.
- R6: `bitten` becomes 1 on the edge that raises `bite` and stays 1 until `clr_flag` is seen without a simultaneous overflow. An overflow wins over a clear in the same cycle.
- R7: A change to `div_sel` has no effect on a period in progress. It is taken only at a service, at an overflow reload, or while disabled.
- R8: On overflow the counter reloads `{reload_hi, 8'h00}` and counts on, so without service the bites repeat with period D*(65536 - 256*reload_hi).
- R9: Synchronous reset `rst` clears `bite` and `bitten`, zeroes the counter and prescaler, and selects ratio code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Watchdog enable |
| div_sel | input | 2 | Prescaler ratio code |
| reload_hi | input | 8 | Reload value for the counter's upper byte |
| kick | input | 1 | Service strobe |
| clr_flag | input | 1 | Clears the sticky fired flag |
| bite | output | 1 | One-cycle reset request |
| bitten | output | 1 | Sticky flag: watchdog has fired |

## Verification
The assertions assume that `reload_hi` is steady whenever a reload can happen, because the checker compares the loaded count against the previous cycle's reload input. They also assume that `rst` is high at the first clock edge. The stimulus changes `reload_hi` and `div_sel` only in the same half-cycle as a service pulse, or during the middle of a period when the select-change case is being tested. It holds `rst` high for several edges from time zero. A behavioural model in the bench tracks every input change, so the cycle-by-cycle comparison still applies during the select-change case.

// File: rtl/guard_timer.sv
module guard_timer #(
  parameter int CW = 16,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [1:0]    div_sel,
  input  logic [RW-1:0] reload_hi,
  input  logic          kick,
  input  logic          clr_flag,
  output logic          bite,
  output logic          bitten
);
  localparam int PW = 8;
  localparam int LW = CW - RW;

  logic [CW-1:0] cnt;
  logic [PW-1:0] pre;
  logic [1:0]    sel_q;
  logic [PW-1:0] pre_top;
  logic          tick, wrap, restart, fire;
  logic [CW-1:0] start_val;

  function automatic logic [PW-1:0] top_of(input logic [1:0] code);
    case (code)
      2'd0:    top_of = PW'(1);
      2'd1:    top_of = PW'(127);
      2'd2:    top_of = PW'(3);
      default: top_of = PW'(255);
    endcase
  endfunction

  assign pre_top   = top_of(sel_q);
  assign tick      = (pre == pre_top);
  assign wrap      = &cnt;
  assign restart   = !en || kick;
  assign fire      = !restart && tick && wrap;
  assign start_val = {reload_hi, {LW{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pre   <= '0;
      sel_q <= 2'd0;
      bite  <= 1'b0;
    end else begin
      bite <= fire;
      if (restart || fire) begin
        cnt   <= start_val;
        pre   <= '0;
        sel_q <= div_sel;
      end else if (tick) begin
        cnt <= cnt + 1'b1;
        pre <= '0;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           bitten <= 1'b0;
    else if (fire)     bitten <= 1'b1;
    else if (clr_flag) bitten <= 1'b0;
  end
endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk #(
  parameter int CW = 16,
  parameter int RW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          kick,
  input logic          clr_flag,
  input logic [RW-1:0] reload_hi,
  input logic          bite,
  input logic          bitten,
  input logic [CW-1:0] cnt
);
  localparam int LW = CW - RW;

  assert_reset_clear_R9: assert property (@(posedge clk) rst |=> (!bite && !bitten && cnt == '0));

  assert_service_load_R2: assert property (@(posedge clk) disable iff (rst)
    (en && kick) |=> (cnt == {$past(reload_hi), {LW{1'b0}}}));

  assert_count_up_R3: assert property (@(posedge clk) disable iff (rst)
    (en && !kick) |=> (bite || cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    bite |=> !bite);

  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!bite && cnt == {$past(reload_hi), {LW{1'b0}}}));

  assert_flag_on_bite_R6: assert property (@(posedge clk) disable iff (rst)
    bite |-> bitten);

  assert_flag_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (bitten && !clr_flag) |=> bitten);

  assert_flag_clears_R6: assert property (@(posedge clk) disable iff (rst)
    clr_flag |=> (!bitten || bite));

  assert_reload_after_bite_R8: assert property (@(posedge clk) disable iff (rst)
    bite |-> (cnt[LW-1:0] == '0));
endmodule

bind guard_timer guard_timer_chk #(.CW(CW), .RW(RW)) u_chk (
  .clk(clk), .rst(rst), .en(en), .kick(kick), .clr_flag(clr_flag),
  .reload_hi(reload_hi), .bite(bite), .bitten(bitten), .cnt(cnt)
);

// File: tb/test_guard_timer.sv
module test_guard_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [1:0] div_sel = 2'd0;
  logic [7:0] reload_hi = 8'd0;
  logic       kick = 1'b0;
  logic       clr_flag = 1'b0;
  logic       bite, bitten;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  guard_timer i_guard_timer (
    .clk(clk), .rst(rst), .en(en), .div_sel(div_sel), .reload_hi(reload_hi),
    .kick(kick), .clr_flag(clr_flag), .bite(bite), .bitten(bitten)
  );

  function automatic int ratio(input logic [1:0] code);
    case (code)
      2'd0: return 2;
      2'd1: return 128;
      2'd2: return 4;
      default: return 256;
    endcase
  endfunction

  int m_cnt = 0, m_pre = 0, m_div = 2;
  bit m_bite = 0, m_flag = 0;

  always @(posedge clk) begin
    bit hit;
    hit = 0;
    if (rst) begin
      m_cnt = 0; m_pre = 0; m_div = 2; m_flag = 0;
    end else begin
      if (!en || kick) begin
        m_cnt = reload_hi * 256; m_pre = 0; m_div = ratio(div_sel);
      end else begin
        m_pre = m_pre + 1;
        if (m_pre == m_div) begin
          m_pre = 0;
          if (m_cnt == 65535) begin
            hit = 1; m_cnt = reload_hi * 256; m_div = ratio(div_sel);
          end else m_cnt = m_cnt + 1;
        end
      end
      if (hit) m_flag = 1;
      else if (clr_flag) m_flag = 0;
    end
    m_bite = hit;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    check(bite == m_bite, "R4 model bite", bite, m_bite);
    check(bitten == m_flag, "R6 model flag", bitten, m_flag);
  end

  task automatic kick_measure(input logic [1:0] s, input logic [7:0] r, input int exp,
                              input int chg_at, input logic [1:0] chg_s, input string req);
    int n;
    @(negedge clk); div_sel = s; reload_hi = r; kick = 1'b1;
    @(negedge clk); kick = 1'b0; n = 1;
    while (!bite && n < exp + 20) begin
      @(negedge clk); n++;
      if (n == chg_at) div_sel = chg_s;
    end
    check(n == exp, req, n, exp);
    @(negedge clk);
    check(bite == 1'b0, "R4 pulse width", bite, 0);
  endtask

  task automatic next_period(input int exp, input string req);
    int n;
    n = 1;
    while (!bite && n < exp + 20) begin
      @(negedge clk); n++;
    end
    check(n == exp, req, n, exp);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(bite == 1'b0, "R9 reset bite", bite, 0);
    check(bitten == 1'b0, "R9 reset flag", bitten, 0);
    rst = 1'b0;
    @(negedge clk); en = 1'b1;

    kick_measure(2'd0, 8'd255, 2*256 + 1, -1, 2'd0, "R1 ratio code0");
    check(bitten == 1'b1, "R6 flag set", bitten, 1);
    @(negedge clk); clr_flag = 1'b1;
    @(negedge clk); clr_flag = 1'b0;
    check(bitten == 1'b0, "R6 flag cleared", bitten, 0);

    kick_measure(2'd2, 8'd255, 4*256 + 1, -1, 2'd0, "R1 ratio code2");
    kick_measure(2'd0, 8'd254, 2*512 + 1, -1, 2'd0, "R2 reload high byte");
    kick_measure(2'd0, 8'd255, 2*256 + 1, 10, 2'd3, "R7 select change mid-period");
    next_period(256*256, "R8 R1 auto reload period with code3");
    @(negedge clk);
    check(bite == 1'b0, "R4 pulse width", bite, 0);
    kick_measure(2'd1, 8'd255, 128*256 + 1, -1, 2'd0, "R1 ratio code1");

    begin
      int seen;
      seen = 0;
      @(negedge clk); en = 1'b0; clr_flag = 1'b1; div_sel = 2'd0; reload_hi = 8'd255;
      @(negedge clk); clr_flag = 1'b0;
      repeat (2000) begin
        @(negedge clk);
        if (bite) seen++;
      end
      check(seen == 0, "R5 disabled never bites", seen, 0);
      check(bitten == 1'b0, "R5 disabled flag stays clear", bitten, 0);
    end
    en = 1'b1;
    next_period(2*256 + 1, "R5 R2 enable starts fresh period");

    @(negedge clk); clr_flag = 1'b1;
    kick_measure(2'd0, 8'd255, 2*256 + 1, -1, 2'd0, "R3 repeat with clear held");
    check(bitten == 1'b0, "R6 clear after overflow cycle", bitten, 0);
    clr_flag = 1'b0;

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule